// File: doc/BRIEF.md
# Normalizing Shift-Subtract Divider

This block divides one unsigned integer by another over several clock cycles and returns both the quotient and the remainder. When a request is accepted, the divisor is first slid left so that its highest set bit lands in the top bit of the working register. The block then runs one compare-and-subtract step per clock. In each step it subtracts the aligned divisor from the running partial remainder if the divisor fits, and it records a quotient bit. After each step it moves the aligned divisor one place to the right. The steps stop once the divisor is back at its original alignment.

The number of steps is therefore one more than the count of leading zeros in the divisor. A divisor with its top bit set finishes in a single step. A divisor of one takes the full register width. Quotient bits come out most significant first and are shifted in at the low end of the quotient register. A zero divisor takes no steps: the block finishes at once and raises a divide-by-zero flag.

A client holds the operands on the inputs and pulses `start` while the block is idle. It then waits for the one-cycle `done` pulse. The results stay on the outputs until the next accepted request.

Top module: `divider`

## Requirements
- R1: While reset is applied and right after it, busy, done and div_by_zero are 0, and quotient and remainder are all zeros.
- R2: A start pulse while idle with a nonzero divisor raises busy in the next cycle. Done is then high for exactly one cycle, in the (L+1)-th cycle after the start edge, where L is the number of leading zeros of the divisor (the count of 0 bits above its highest 1 bit). Busy and done are never high together.
- R3: At done with div_by_zero low, quotient equals the dividend divided by the divisor rounded down, and remainder equals the dividend modulo the divisor, which is smaller than the divisor.
- R4: When the dividend is smaller than the nonzero divisor, the result is quotient 0 and remainder equal to the dividend.
- R5: A start pulse while idle with divisor 0 never raises busy. Done and div_by_zero are high in the first cycle after the start edge, quotient is all ones and remainder equals the dividend.
- R6: A start pulse while busy is ignored. The running division keeps its operands, its result and its done cycle.
- R7: While idle and start is low, quotient, remainder and div_by_zero do not change, even if the operand inputs change.
- R8: An accepted start with a nonzero divisor clears a div_by_zero left from an earlier request, so the flag is low at its done.
- R9: A divisor whose top bit is 1 needs no normalizing shift. It completes in one step, with quotient 1 if the dividend is at least the divisor and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, accepted only while idle |
| dividend | input | W | Unsigned dividend, sampled when start is accepted |
| divisor | input | W | Unsigned divisor, sampled when start is accepted |
| busy | output | 1 | High while the subtract steps run |
| done | output | 1 | One-cycle pulse when results are valid |
| quotient | output | W | Unsigned quotient, held until the next accepted start |
| remainder | output | W | Unsigned remainder, held until the next accepted start |
| div_by_zero | output | 1 | High when the last accepted request had divisor 0 |

## Verification
The bench builds the divider with its default width of 8 bits. At that width every divisor value from 1 to 255 can be swept against fixed dividends, so every normalization shift from 0 to 7 is exercised, together with its exact latency. At the same width a few hundred further random operand pairs, the zero-divisor path and the divisor-above-dividend case run in a few thousand cycles.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

endpackage

// File: rtl/div_lead_zero.sv
module div_lead_zero #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  value,
    output logic [CW-1:0] zeros
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic seen;

    // Count zero bits above the highest set bit, scanning from the top.
    always_comb begin
        zeros = '0;
        seen  = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!seen) begin
                if (value[i]) begin
                    seen = 1'b1;
                end else begin
                    zeros = zeros + ONE;
                end
            end
        end
    end
endmodule

// File: rtl/div_step.sv
module div_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] part_rem,
    input  logic [W-1:0] aligned_dvs,
    output logic [W-1:0] next_rem,
    output logic         q_bit
);
    // One restoring step: subtract only when the aligned divisor fits.
    always_comb begin
        q_bit    = (part_rem >= aligned_dvs);
        next_rem = q_bit ? (part_rem - aligned_dvs) : part_rem;
    end
endmodule

// File: rtl/divider.sv
module divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_by_zero
);
    import div_pkg::*;

    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    typedef struct packed {
        div_state_e   st;
        logic [W-1:0] rem;
        logic [W-1:0] dvs;
        logic [W-1:0] quo;
        logic [CW-1:0] cnt;
        logic         done;
        logic         dbz;
    } div_regs_t;

    div_regs_t r_q, r_d;

    logic [CW-1:0] lz_cnt;
    logic [W-1:0]  step_rem;
    logic          step_bit;

    div_lead_zero #(.W(W), .CW(CW)) lz_i (
        .value (divisor),
        .zeros (lz_cnt)
    );

    div_step #(.W(W)) step_i (
        .part_rem    (r_q.rem),
        .aligned_dvs (r_q.dvs),
        .next_rem    (step_rem),
        .q_bit       (step_bit)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (divisor == '0) begin
                        r_d.done = 1'b1;
                        r_d.dbz  = 1'b1;
                        r_d.quo  = '1;
                        r_d.rem  = dividend;
                    end else begin
                        r_d.st  = ST_RUN;
                        r_d.dbz = 1'b0;
                        r_d.rem = dividend;
                        r_d.dvs = divisor << lz_cnt;
                        r_d.cnt = lz_cnt;
                        r_d.quo = '0;
                    end
                end
            end
            ST_RUN: begin
                r_d.rem = step_rem;
                r_d.quo = {r_q.quo[W-2:0], step_bit};
                r_d.dvs = r_q.dvs >> 1;
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_ONE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, rem: '0, dvs: '0, quo: '0, cnt: '0,
                     done: 1'b0, dbz: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.st == ST_RUN);
    assign done        = r_q.done;
    assign quotient    = r_q.quo;
    assign remainder   = r_q.rem;
    assign div_by_zero = r_q.dbz;
endmodule

// File: rtl/divider_chk.sv
module divider_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder,
    input logic         div_by_zero
);
    logic [W-1:0] a_q, b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (start && !busy) begin
            a_q <= dividend;
            b_q <= divisor;
        end
    end

    assert_busy_done_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_identity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_by_zero) |->
            (((2*W)'(quotient) * (2*W)'(b_q) + (2*W)'(remainder)) == (2*W)'(a_q))
            && (remainder < b_q));

    assert_zero_divisor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor == '0) |=>
            (done && div_by_zero && !busy && quotient == '1));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=>
            ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));
endmodule

bind divider divider_chk #(.W(W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .dividend    (dividend),
    .divisor     (divisor),
    .busy        (busy),
    .done        (done),
    .quotient    (quotient),
    .remainder   (remainder),
    .div_by_zero (div_by_zero)
);

// File: tb/divider_tb_top.sv
module divider_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_by_zero;
    logic [W-1:0] quotient, remainder;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    divider #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
        .remainder(remainder), .div_by_zero(div_by_zero)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run exceeded cycle limit");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lead_zeros(input logic [W-1:0] v);
        int n = 0;
        for (int i = W - 1; i >= 0; i--) begin
            if (v[i]) return n;
            n++;
        end
        return n;
    endfunction

    // Pulse start for one cycle; returns cycles until done (1 = first cycle after edge).
    task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b,
                           input bool_inject, output int lat);
        @(negedge clk);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        if (bool_inject && busy) begin
            dividend = ~a;
            divisor  = 8'd1;
            start    = 1'b1;
        end
        while (!done && lat < 4 * W) begin
            @(negedge clk);
            start = 1'b0;
            if (!done) lat++;
        end
    endtask

    task automatic check_result(input string req, input logic [W-1:0] a, input logic [W-1:0] b);
        int lat;
        run_div(a, b, 1'b0, lat);
        chk({req, " done"}, done, 1);
        chk({req, " latency"}, lat, lead_zeros(b) + 1);
        chk({req, " quotient"}, quotient, a / b);
        chk({req, " remainder"}, remainder, a % b);
        chk({req, " dbz"}, div_by_zero, 0);
    endtask

    task automatic t_reset();
        #1;
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 dbz", div_by_zero, 0);
        chk("R1 quotient", quotient, 0);
        chk("R1 remainder", remainder, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after release", busy, 0);
        chk("R1 quotient after release", quotient, 0);
    endtask

    task automatic t_example();
        int lat;
        run_div(8'd220, 8'd12, 1'b0, lat);
        chk("R3 220/12 quotient", quotient, 18);
        chk("R3 220/12 remainder", remainder, 4);
        chk("R2 220/12 latency", lat, 5);
        @(negedge clk);
        chk("R2 done single cycle", done, 0);
    endtask

    task automatic t_busy_rise();
        @(negedge clk);
        dividend = 8'd100; divisor = 8'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", busy, 1);
        while (!done) @(negedge clk);
        chk("R3 100/3 quotient", quotient, 33);
        chk("R2 busy low at done", busy, 0);
    endtask

    task automatic t_sweep_divisor();
        for (int b = 1; b < 256; b++) check_result("R3 sweep 255", 8'd255, 8'(b));
        for (int b = 1; b < 256; b++) check_result("R2 sweep 170", 8'd170, 8'(b));
    endtask

    task automatic t_random();
        for (int k = 0; k < 300; k++) begin
            logic [W-1:0] a, b;
            a = 8'($urandom);
            b = 8'($urandom);
            if (b == 0) b = 8'd7;
            check_result("R3 random", a, b);
        end
    endtask

    task automatic t_small_dividend();
        check_result("R4 5/9", 8'd5, 8'd9);
        check_result("R4 0/1", 8'd0, 8'd1);
        check_result("R4 254/255", 8'd254, 8'd255);
        int_chk_zero_q();
    endtask

    task automatic int_chk_zero_q();
        chk("R4 quotient zero", quotient, 0);
        chk("R4 remainder is dividend", remainder, 254);
    endtask

    task automatic t_zero_divisor();
        int lat;
        run_div(8'd77, 8'd0, 1'b0, lat);
        chk("R5 latency", lat, 1);
        chk("R5 dbz", div_by_zero, 1);
        chk("R5 quotient all ones", quotient, 8'hFF);
        chk("R5 remainder", remainder, 77);
        chk("R5 busy", busy, 0);
    endtask

    task automatic t_clear_dbz();
        int lat;
        run_div(8'd9, 8'd0, 1'b0, lat);
        chk("R8 dbz set", div_by_zero, 1);
        run_div(8'd9, 8'd2, 1'b0, lat);
        chk("R8 dbz cleared", div_by_zero, 0);
        chk("R8 quotient", quotient, 4);
    endtask

    task automatic t_start_while_busy();
        int lat;
        run_div(8'd200, 8'd1, 1'b1, lat);
        chk("R6 latency kept", lat, 8);
        chk("R6 quotient kept", quotient, 200);
        chk("R6 remainder kept", remainder, 0);
        @(negedge clk);
        chk("R6 no second run", busy, 0);
    endtask

    task automatic t_idle_hold();
        int lat;
        run_div(8'd50, 8'd6, 1'b0, lat);
        dividend = 8'd3; divisor = 8'd0;
        repeat (4) @(negedge clk);
        chk("R7 quotient held", quotient, 8);
        chk("R7 remainder held", remainder, 2);
        chk("R7 dbz held", div_by_zero, 0);
        chk("R7 busy idle", busy, 0);
    endtask

    task automatic t_top_bit();
        int lat;
        run_div(8'd200, 8'd130, 1'b0, lat);
        chk("R9 latency", lat, 1);
        chk("R9 quotient one", quotient, 1);
        chk("R9 remainder", remainder, 70);
        run_div(8'd100, 8'd130, 1'b0, lat);
        chk("R9 quotient zero", quotient, 0);
        chk("R9 remainder small", remainder, 100);
    endtask

    initial begin
        t_reset();
        t_example();
        t_busy_rise();
        t_sweep_divisor();
        t_random();
        t_small_dividend();
        t_zero_divisor();
        t_clear_dbz();
        t_start_while_busy();
        t_idle_hold();
        t_top_bit();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule